// File: doc/BRIEF.md
# Dual-Issue Warp Dispatch Arbiter

This block is the issue stage of one shader core. It holds a pool of warp contexts (each a group of 32 threads that share one instruction stream) and runs two schedulers side by side. Each cycle each scheduler may send one instruction, on behalf of a whole warp, to one of three shared execution pools: a 16-lane core group, a 16-lane load/store group, or a 4-lane special-function group. The two schedulers own disjoint halves of the warp pool, so two different warps can issue in the same cycle.

The arbiter tracks how long each pool stays occupied. A 16-lane pool needs two cycles to serve 32 threads. The 4-lane special-function pool needs eight cycles. While the special-function pool is busy, both schedulers keep issuing to the other two pools. After a warp issues, it waits in a pending state until its completion is signalled. Decode, operand fetch and the execution datapaths themselves sit outside this block.

Top module: `warp_issue_arbiter`

## Requirements
- R1: While reset is asserted, no issue is valid. Reset clears every pending flag and every busy pool, and it sets both round-robin positions so that the next search starts at local warp 0.
- R2: The class of warp w is the 2-bit field `warp_class_i[2w+1:2w]`: 0 is the core group, 1 is load/store, 2 is special-function and 3 is reserved. An issue reports its target in the same code. A warp whose class is 3 never issues.
- R3: Scheduler 0 serves the even-numbered warps and scheduler 1 serves the odd-numbered warps. Both can issue in the same cycle, each on its own port.
- R4: After an issue to the core group or to the load/store group, that group accepts no new issue in the next cycle. It accepts one again two cycles after the first issue.
- R5: After an issue to the special-function pool, that pool accepts no new issue for the next 7 cycles. It accepts one again 8 cycles after the first issue.
- R6: While the special-function pool is busy, warps that target the other pools keep issuing.
- R7: If both schedulers could use the same free pool in one cycle, scheduler 0 gets it. Scheduler 1 then issues another of its warps whose pool is still free, or it issues nothing and tries again in a later cycle.
- R8: Each scheduler selects round-robin among its eligible warps. The search starts at the warp after the one it last issued.
- R9: An issued warp is not eligible again until its bit in `warp_done_i` is pulsed. A done pulse in a later cycle makes it eligible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_ready_i | input | NUM_WARPS | Warp w has an instruction waiting |
| warp_class_i | input | 2*NUM_WARPS | Target class of each warp's waiting instruction |
| warp_done_i | input | NUM_WARPS | One-cycle completion pulse per warp |
| iss_vld_o | output | 2 | Bit s: scheduler s issues this cycle |
| iss_warp_o | output | 2*WW | Warp ID of scheduler s at bits [s*WW +: WW] |
| iss_unit_o | output | 4 | Target pool of scheduler s at bits [2s+1:2s] |

## Verification
The bench goes after four kinds of error. A design that counted pool occupancy wrong would issue again into a busy pool, or leave a free pool idle. A design that got the special-function window wrong would show up in the cycle before the eighth, and in the eighth cycle itself. Port contention is checked in two ways: a design without scheduler 0 priority, or one in which scheduler 1 stalls instead of taking another free pool, would report the wrong warp on port 1. Finally, the bench walks a single scheduler through its whole warp list and back to the start, which exposes a round-robin pointer that does not advance or does not wrap. It also checks that a warp is not issued again before its done pulse and that a reserved class is never issued.

// File: rtl/warp_issue_arbiter.sv
module warp_issue_arbiter #(
  parameter int NUM_WARPS = 32,
  parameter int CORE_CYC  = 2,
  parameter int LDST_CYC  = 2,
  parameter int SPEC_CYC  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_WARPS-1:0]          warp_ready_i,
  input  logic [2*NUM_WARPS-1:0]        warp_class_i,
  input  logic [NUM_WARPS-1:0]          warp_done_i,
  output logic [1:0]                    iss_vld_o,
  output logic [2*$clog2(NUM_WARPS)-1:0] iss_warp_o,
  output logic [3:0]                    iss_unit_o
);
  localparam int WW   = $clog2(NUM_WARPS);
  localparam int HALF = NUM_WARPS / 2;
  localparam int HW   = $clog2(HALF);
  localparam int M01  = (CORE_CYC > LDST_CYC) ? CORE_CYC : LDST_CYC;
  localparam int MAXC = (M01 > SPEC_CYC) ? M01 : SPEC_CYC;
  localparam int CNTW = $clog2(MAXC + 1);
  localparam int UCYC [3] = '{CORE_CYC, LDST_CYC, SPEC_CYC};

  logic [CNTW-1:0]      busy_q [3];
  logic [NUM_WARPS-1:0] pend_q;
  logic [HW-1:0]        ptr_q  [2];

  logic [1:0]           vld;
  logic [HW-1:0]        pick   [2];
  logic [1:0]           unit   [2];
  logic [NUM_WARPS-1:0] set_mask;
  logic [2:0]           unit_hit;

  always_comb begin
    logic [3:0] freem;
    int idx;
    int w;
    logic [1:0] c;
    idx = 0;
    w = 0;
    c = 2'd0;
    for (int u = 0; u < 3; u++) freem[u] = (busy_q[u] == '0);
    freem[3] = 1'b0;
    vld = '0;
    set_mask = '0;
    for (int s = 0; s < 2; s++) begin
      pick[s] = '0;
      unit[s] = 2'd0;
      for (int k = 1; k <= HALF; k++) begin
        idx = (int'(ptr_q[s]) + k) % HALF;
        w = 2 * idx + s;
        c = warp_class_i[2*w +: 2];
        if (rst_n && !vld[s] && warp_ready_i[w] && !pend_q[w] && freem[c]) begin
          vld[s]  = 1'b1;
          pick[s] = HW'(idx);
          unit[s] = c;
        end
      end
      if (vld[s]) begin
        freem[unit[s]] = 1'b0;
        set_mask[{pick[s], 1'(s)}] = 1'b1;
      end
    end
    for (int u = 0; u < 3; u++)
      unit_hit[u] = (vld[0] && unit[0] == 2'(u)) || (vld[1] && unit[1] == 2'(u));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int u = 0; u < 3; u++) busy_q[u] <= '0;
      for (int s = 0; s < 2; s++) ptr_q[s] <= HW'(HALF - 1);
    end else begin
      pend_q <= (pend_q & ~warp_done_i) | set_mask;
      for (int u = 0; u < 3; u++) begin
        if (unit_hit[u])           busy_q[u] <= CNTW'(UCYC[u] - 1);
        else if (busy_q[u] != '0)  busy_q[u] <= busy_q[u] - 1'b1;
      end
      for (int s = 0; s < 2; s++)
        if (vld[s]) ptr_q[s] <= pick[s];
    end
  end

  assign iss_vld_o = vld;
  assign iss_warp_o = {pick[1], 1'b1, pick[0], 1'b0};
  assign iss_unit_o = {unit[1], unit[0]};

  AST_UNIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    |iss_vld_o |-> ((!iss_vld_o[0] || iss_unit_o[1:0] != 2'd3) &&
                    (!iss_vld_o[1] || iss_unit_o[3:2] != 2'd3)));  // R2
  AST_PORT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld_o[1] |-> iss_warp_o[WW]);  // R3
  AST_NO_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
    (&iss_vld_o) |-> (iss_unit_o[1:0] != iss_unit_o[3:2]));  // R7
  AST_CORE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (CORE_CYC > 1 && unit_hit[0]) |=> !unit_hit[0]);  // R4
  AST_SPEC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (SPEC_CYC > 1 && unit_hit[2]) |=> !unit_hit[2]);  // R5
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld_o[0] |=> !(iss_vld_o[0] && iss_warp_o[WW-1:0] == $past(iss_warp_o[WW-1:0])));  // R9
endmodule

// File: tb/warp_issue_arbiter_bench.sv
`timescale 1ns/1ps
module warp_issue_arbiter_bench;
  localparam int NW = 8;
  localparam int WW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NW-1:0]   ready = '0;
  logic [2*NW-1:0] cls = '0;
  logic [NW-1:0]   done = '0;
  logic [1:0]      vld;
  logic [2*WW-1:0] warp;
  logic [3:0]      unit;
  int tests = 0;
  int fails = 0;
  bit finished = 0;

  warp_issue_arbiter #(.NUM_WARPS(NW)) u_warp_issue_arbiter (
    .clk(clk), .rst_n(rst_n), .warp_ready_i(ready), .warp_class_i(cls),
    .warp_done_i(done), .iss_vld_o(vld), .iss_warp_o(warp), .iss_unit_o(unit));

  always #2.5 clk = ~clk;

  // {done[7:0], vld[1:0], w0[2:0], u0[1:0], w1[2:0], u1[1:0]}
  localparam logic [19:0] VEC [10] = '{
    {8'h00, 2'b11, 3'd0, 2'd0, 3'd1, 2'd1},
    {8'h00, 2'b01, 3'd2, 2'd2, 3'd0, 2'd0},
    {8'h00, 2'b11, 3'd4, 2'd1, 3'd3, 2'd0},
    {8'h01, 2'b00, 3'd0, 2'd0, 3'd0, 2'd0},
    {8'h00, 2'b11, 3'd6, 2'd0, 3'd7, 2'd1},
    {8'h00, 2'b00, 3'd0, 2'd0, 3'd0, 2'd0},
    {8'h00, 2'b01, 3'd0, 2'd0, 3'd0, 2'd0},
    {8'h00, 2'b00, 3'd0, 2'd0, 3'd0, 2'd0},
    {8'h00, 2'b00, 3'd0, 2'd0, 3'd0, 2'd0},
    {8'h00, 2'b10, 3'd0, 2'd0, 3'd5, 2'd2}
  };

  task automatic cyc(input logic [7:0] rdy, input logic [7:0] dn, input logic [1:0] ev,
                     input int ew0, input int eu0, input int ew1, input int eu1, input string tag);
    bit bad;
    ready = rdy;
    done = dn;
    #1;
    tests++;
    bad = (vld !== ev);
    if (ev[0] && (warp[2:0] !== 3'(ew0) || unit[1:0] !== 2'(eu0))) bad = 1;
    if (ev[1] && (warp[5:3] !== 3'(ew1) || unit[3:2] !== 2'(eu1))) bad = 1;
    if (bad) begin
      fails++;
      $display("FAIL %s: got vld=%b w0=%0d u0=%0d w1=%0d u1=%0d, expected vld=%b w0=%0d u0=%0d w1=%0d u1=%0d",
               tag, vld, warp[2:0], unit[1:0], warp[5:3], unit[3:2], ev, ew0, eu0, ew1, eu1);
    end
    @(negedge clk);
    done = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ready = '0;
    done = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: no issue while reset is held, even with every warp ready
    rst_n = 1'b0;
    cls = 16'h0000;
    @(negedge clk);
    ready = 8'hFF;
    #1;
    tests++;
    if (vld !== 2'b00) begin
      fails++;
      $display("FAIL R1 reset: got vld=%b, expected vld=00", vld);
    end

    // Table: mixed classes, R3 R4 R5 R6 R8 R9
    do_reset();
    cls = 16'h4924;
    for (int i = 0; i < 10; i++)
      cyc(8'hFF, VEC[i][19:12], VEC[i][11:10], int'(VEC[i][9:7]), int'(VEC[i][6:5]),
          int'(VEC[i][4:2]), int'(VEC[i][1:0]), $sformatf("R3/R4/R5/R6 vector %0d", i));

    // R7: both want the core group, scheduler 0 wins, scheduler 1 retries
    do_reset();
    cls = 16'h0000;
    cyc(8'h03, 8'h00, 2'b01, 0, 0, 0, 0, "R7 priority");
    cyc(8'h03, 8'h00, 2'b00, 0, 0, 0, 0, "R4 core busy");
    cyc(8'h03, 8'h00, 2'b10, 0, 0, 1, 0, "R7 retry");

    // R7: scheduler 1 redirects to a warp whose pool is free
    do_reset();
    cls = 16'h0040;
    cyc(8'h0B, 8'h00, 2'b11, 0, 0, 3, 1, "R7 redirect");

    // R8: round-robin through all even warps and wrap
    do_reset();
    cls = 16'h0000;
    cyc(8'h55, 8'h00, 2'b01, 0, 0, 0, 0, "R8 rr w0");
    cyc(8'h55, 8'h01, 2'b00, 0, 0, 0, 0, "R8 rr gap");
    cyc(8'h55, 8'h00, 2'b01, 2, 0, 0, 0, "R8 rr w2");
    cyc(8'h55, 8'h04, 2'b00, 0, 0, 0, 0, "R8 rr gap");
    cyc(8'h55, 8'h00, 2'b01, 4, 0, 0, 0, "R8 rr w4");
    cyc(8'h55, 8'h10, 2'b00, 0, 0, 0, 0, "R8 rr gap");
    cyc(8'h55, 8'h00, 2'b01, 6, 0, 0, 0, "R8 rr w6");
    cyc(8'h55, 8'h40, 2'b00, 0, 0, 0, 0, "R8 rr gap");
    cyc(8'h55, 8'h00, 2'b01, 0, 0, 0, 0, "R8 rr wrap w0");

    // R9: pending until done
    do_reset();
    cyc(8'h01, 8'h00, 2'b01, 0, 0, 0, 0, "R9 first issue");
    for (int i = 0; i < 4; i++)
      cyc(8'h01, 8'h00, 2'b00, 0, 0, 0, 0, "R9 held pending");
    cyc(8'h01, 8'h01, 2'b00, 0, 0, 0, 0, "R9 done pulse");
    cyc(8'h01, 8'h00, 2'b01, 0, 0, 0, 0, "R9 reissue");

    // R2: reserved class never issues
    do_reset();
    cls = 16'hFFFF;
    for (int i = 0; i < 3; i++)
      cyc(8'hFF, 8'h00, 2'b00, 0, 0, 0, 0, "R2 reserved class");
    cls = 16'hFFFE;
    cyc(8'hFF, 8'h00, 2'b01, 0, 2, 0, 0, "R2 special code");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule